// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits in front of an embedded flash array and decides, for each request, whether a read, a program, a page erase or a mass erase may go ahead. It looks at the read-protection state, a vector of write-protection bits, the boot source, whether debug is active, and which agent makes the request. A CPU can fetch from flash, a CPU can run code from SRAM or external memory, and DMA and the debug port can also make requests. The grant is combinational, so the array controller can act on it in the same cycle. A registered response reports the decision one cycle later.

Write protection uses two granularities. Below a boundary page, each pair of pages has its own protection bit. A single last bit covers every page from the boundary to the top of the array. When read protection is active, three further rules apply:
- Only trusted CPU code may read.
- The lowest pages are locked against writes.
- Any program or page erase is refused while debug is active or after booting from SRAM.

Mass erase is never refused. A refused program or erase sets a sticky error flag, and software clears it by writing a one. A refused read returns all zeros and sets no flag.

Top module: `flash_access_guard`

## Requirements
- R1: The page index is the byte address above its low 10 bits. For program (op 1) or page erase (op 2) of a page p below 62, the request is refused when wpBits[p/2] is 0 and allowed when it is 1, provided no read-protection rule refuses it.
- R2: Every page from 62 to 127 follows the single bit wpBits[31]. A value of 0 refuses program and page erase anywhere in that range, and pages 60 and 61 are unaffected by it.
- R3: A refused program or page erase sets protErr at the next clock edge. protErr stays set until a cycle with errClr high and no new refusal clears it at the next edge. A refusal in the same cycle as errClr keeps the flag set.
- R4: With rdpActive high, a read (op 0) is granted only to source 0, the CPU running from flash, and only with bootFromSram low and debugActive low. Sources 1 (CPU from SRAM or external memory), 2 (DMA) and 3 (debug port) are refused. A refused read returns rdataOut of zero and leaves protErr unchanged.
- R5: With rdpActive high, pages 0 and 1 refuse program and page erase even when their wpBits are 1. Page 2 is not affected by this rule.
- R6: With rdpActive high and either debugActive or bootFromSram high, program and page erase of any page are refused. With rdpActive low, these two inputs do not restrict writes.
- R7: Mass erase (op 3) is granted whatever the protection state, boot source, debug state and requester, and it never sets protErr.
- R8: With rdpActive low, reads are granted to every requester whatever wpBits holds. The array data then appears on rdataOut in the cycle after the request.
- R9: rspValid and rspGrant show the request and its decision one cycle after reqValid. After reset, rspValid, protErr and rdataOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 read, 1 program, 2 page erase, 3 mass erase |
| reqSrc | input | 2 | 0 CPU from flash, 1 CPU from SRAM/external, 2 DMA, 3 debug port |
| reqAddr | input | ADDR_W | Byte address of the request |
| rdpActive | input | 1 | Loaded read-protection state |
| wpBits | input | WP_W | Write-protection bits, 0 = group protected |
| bootFromSram | input | 1 | Device booted from SRAM |
| debugActive | input | 1 | Debug session active |
| errClr | input | 1 | Write-one-to-clear of the error flag |
| arrayRdata | input | DATA_W | Read data from the flash array, one cycle after the request |
| reqGrant | output | 1 | Combinational grant for the current request |
| rspValid | output | 1 | Registered response strobe |
| rspGrant | output | 1 | Registered decision |
| protErr | output | 1 | Sticky protection error flag |
| rdataOut | output | DATA_W | Array data when the read was granted, otherwise zero |

## Verification
The bench builds the block with its default parameters: 17 address bits and 1 KiB pages. This gives 128 pages, a pair boundary at page 62, two auto-locked pages and 32 protection bits. With these values, both sides of every edge can be tested directly: the last paired pages 60 and 61, the first shared page 62, the top page 127, and the step between page 1 and page 2 under read protection. The tests also cover every requester code under read protection, along with the flag behaviour when a refusal and a clear arrive in the same cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_FLASH_CPU = 2'd0,
    SRC_RAM_CPU   = 2'd1,
    SRC_DMA       = 2'd2,
    SRC_DEBUG     = 2'd3
  } src_e;

  // strobes from control to datapath, all already qualified by reqValid
  typedef struct packed {
    logic grant;
    logic errSet;
    logic rdLatch;
  } strobe_t;

endpackage

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter int PAGE_W     = 7,
  parameter int DATA_W     = 32,
  parameter int PAIR_PAGES = 62,
  parameter int AUTO_PAGES = 2,
  parameter int GROUP      = 2,
  parameter int WP_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] pageIdx,
  input  logic [WP_W-1:0]   wpBits,
  input  logic              rdpActive,
  input  strobe_t           st,
  input  logic              errClr,
  input  logic [DATA_W-1:0] arrayRdata,
  output logic              pageLocked,
  output logic              protErr,
  output logic [DATA_W-1:0] rdataOut
);

  localparam int NUM_PAGES = 1 << PAGE_W;

  logic [NUM_PAGES-1:0] pageProt;
  logic                 rdGateQ;

  // per-page lock map: paired groups below the boundary, one shared bit above
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    localparam int GRP = (p < PAIR_PAGES) ? (p / GROUP) : (WP_W - 1);
    if (p < AUTO_PAGES) begin : g_auto
      assign pageProt[p] = ~wpBits[GRP] | rdpActive;
    end else begin : g_plain
      assign pageProt[p] = ~wpBits[GRP];
    end
  end

  assign pageLocked = pageProt[pageIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdGateQ <= 1'b0;
      protErr <= 1'b0;
    end else begin
      rdGateQ <= st.rdLatch;
      if (st.errSet)   protErr <= 1'b1;
      else if (errClr) protErr <= 1'b0;
    end
  end

  assign rdataOut = rdGateQ ? arrayRdata : '0;

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    protErr && !errClr |=> protErr);

  p_err_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    errClr && !st.errSet |=> !protErr);

  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protErr) |-> $past(st.errSet));

endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  op_e     op,
  input  src_e    src,
  input  logic    rdpActive,
  input  logic    bootFromSram,
  input  logic    debugActive,
  input  logic    pageLocked,
  output strobe_t st,
  output logic    reqGrant,
  output logic    rspValid,
  output logic    rspGrant
);

  logic trustedRead;
  logic rdpWriteBlock;
  logic isWrite;
  logic allow;

  assign trustedRead   = (src == SRC_FLASH_CPU) && !bootFromSram && !debugActive;
  assign rdpWriteBlock = rdpActive && (debugActive || bootFromSram);
  assign isWrite       = (op == OP_PROG) || (op == OP_PERASE);

  always_comb begin
    unique case (op)
      OP_READ:   allow = !rdpActive || trustedRead;
      OP_PROG,
      OP_PERASE: allow = !pageLocked && !rdpWriteBlock;
      OP_MERASE: allow = 1'b1;
      default:   allow = 1'b0;
    endcase
  end

  always_comb begin
    st.grant   = reqValid && allow;
    st.errSet  = reqValid && isWrite && !allow;
    st.rdLatch = reqValid && (op == OP_READ) && allow;
  end

  assign reqGrant = st.grant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspGrant <= st.grant;
    end
  end

  p_mass_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && op == OP_MERASE |-> reqGrant && !st.errSet);

  p_rsp_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && !rspGrant);

  p_untrusted_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && op == OP_READ && rdpActive && src != SRC_FLASH_CPU |-> !reqGrant);

  p_read_no_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && op == OP_READ |-> !st.errSet);

  p_open_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && op == OP_READ && !rdpActive |-> reqGrant);

endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard
  import fpc_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_OFF_W = 10,
  parameter int DATA_W     = 32,
  parameter int PAIR_PAGES = 62,
  parameter int AUTO_PAGES = 2,
  localparam int GROUP     = 2,
  localparam int PAGE_W    = ADDR_W - PAGE_OFF_W,
  localparam int WP_W      = PAIR_PAGES / GROUP + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [1:0]        reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              rdpActive,
  input  logic [WP_W-1:0]   wpBits,
  input  logic              bootFromSram,
  input  logic              debugActive,
  input  logic              errClr,
  input  logic [DATA_W-1:0] arrayRdata,
  output logic              reqGrant,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              protErr,
  output logic [DATA_W-1:0] rdataOut
);

  localparam int GRP_W = $clog2(WP_W);

  logic [PAGE_W-1:0] pageIdx;
  logic              pageLocked;
  strobe_t           st;
  op_e               op;
  src_e              src;

  assign pageIdx = reqAddr[ADDR_W-1:PAGE_OFF_W];
  assign op      = op_e'(reqOp);
  assign src     = src_e'(reqSrc);

  fpc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .op          (op),
    .src         (src),
    .rdpActive   (rdpActive),
    .bootFromSram(bootFromSram),
    .debugActive (debugActive),
    .pageLocked  (pageLocked),
    .st          (st),
    .reqGrant    (reqGrant),
    .rspValid    (rspValid),
    .rspGrant    (rspGrant)
  );

  fpc_datapath #(
    .PAGE_W    (PAGE_W),
    .DATA_W    (DATA_W),
    .PAIR_PAGES(PAIR_PAGES),
    .AUTO_PAGES(AUTO_PAGES),
    .GROUP     (GROUP),
    .WP_W      (WP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pageIdx   (pageIdx),
    .wpBits    (wpBits),
    .rdpActive (rdpActive),
    .st        (st),
    .errClr    (errClr),
    .arrayRdata(arrayRdata),
    .pageLocked(pageLocked),
    .protErr   (protErr),
    .rdataOut  (rdataOut)
  );

  logic             isWrite;
  logic [GRP_W-1:0] pairGrp;

  assign isWrite = reqValid && (reqOp == 2'd1 || reqOp == 2'd2);
  assign pairGrp = GRP_W'(pageIdx >> 1);

  p_pair_lock_r1: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && (int'(pageIdx) < PAIR_PAGES) && !wpBits[pairGrp] |-> !reqGrant);

  p_upper_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && (int'(pageIdx) >= PAIR_PAGES) && !wpBits[WP_W-1] |-> !reqGrant);

  p_auto_pages_r5: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && rdpActive && (int'(pageIdx) < AUTO_PAGES) |-> !reqGrant);

  p_rdp_debug_r6: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && rdpActive && (debugActive || bootFromSram) |-> !reqGrant);

endmodule

// File: tb/flash_access_guard_tb.sv
`timescale 1ns/1ps
module flash_access_guard_tb;

  localparam logic [31:0] PAT = 32'hC0DE_1234;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [1:0]  reqSrc = 2'd0;
  logic [16:0] reqAddr = '0;
  logic        rdpActive = 1'b0;
  logic [31:0] wpBits = '1;
  logic        bootFromSram = 1'b0;
  logic        debugActive = 1'b0;
  logic        errClr = 1'b0;
  logic [31:0] arrayRdata = PAT;
  logic        reqGrant, rspValid, rspGrant, protErr;
  logic [31:0] rdataOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_access_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqSrc(reqSrc),
    .reqAddr(reqAddr), .rdpActive(rdpActive), .wpBits(wpBits),
    .bootFromSram(bootFromSram), .debugActive(debugActive), .errClr(errClr),
    .arrayRdata(arrayRdata), .reqGrant(reqGrant), .rspValid(rspValid),
    .rspGrant(rspGrant), .protErr(protErr), .rdataOut(rdataOut)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request: grant checked in its cycle, response and read data one cycle later
  task automatic doReq(input logic [1:0] op, input logic [1:0] src, input int page,
                       input logic expGrant, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqSrc = src;
    reqAddr = {page[6:0], 10'h15C};
    #1 checkEq({req, " grant"}, {31'd0, reqGrant}, {31'd0, expGrant});
    @(negedge clk);
    reqValid = 1'b0;
    checkEq({req, " rspValid"}, {31'd0, rspValid}, 32'd1);
    checkEq({req, " rspGrant"}, {31'd0, rspGrant}, {31'd0, expGrant});
    if (op == 2'd0) checkEq({req, " rdata"}, rdataOut, expGrant ? PAT : 32'd0);
  endtask

  task automatic clearErr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    checkEq("R3 cleared", {31'd0, protErr}, 32'd0);
  endtask

  task automatic t_reset();
    checkEq("R9 reset rspValid", {31'd0, rspValid}, 32'd0);
    checkEq("R9 reset protErr", {31'd0, protErr}, 32'd0);
    checkEq("R9 reset rdata", rdataOut, 32'd0);
  endtask

  task automatic t_pairs();
    wpBits = '1; wpBits[5] = 1'b0;
    doReq(2'd1, 2'd0, 10, 1'b0, "R1 page10 locked");
    doReq(2'd2, 2'd0, 11, 1'b0, "R1 page11 locked");
    doReq(2'd1, 2'd0, 9, 1'b1, "R1 page9 open");
    doReq(2'd2, 2'd0, 12, 1'b1, "R1 page12 open");
    wpBits = '1; wpBits[30] = 1'b0;
    doReq(2'd1, 2'd0, 60, 1'b0, "R1 page60 locked");
    doReq(2'd1, 2'd0, 61, 1'b0, "R1 page61 locked");
    doReq(2'd1, 2'd0, 62, 1'b1, "R1 page62 open");
    clearErr();
  endtask

  task automatic t_upper();
    wpBits = '1; wpBits[31] = 1'b0;
    doReq(2'd1, 2'd0, 62, 1'b0, "R2 page62 locked");
    doReq(2'd2, 2'd0, 100, 1'b0, "R2 page100 locked");
    doReq(2'd1, 2'd0, 127, 1'b0, "R2 page127 locked");
    doReq(2'd1, 2'd0, 61, 1'b1, "R2 page61 open");
    doReq(2'd2, 2'd0, 60, 1'b1, "R2 page60 open");
    wpBits = '1;
    clearErr();
  endtask

  task automatic t_err();
    wpBits = '1; wpBits[0] = 1'b0;
    checkEq("R3 start clear", {31'd0, protErr}, 32'd0);
    doReq(2'd1, 2'd0, 0, 1'b0, "R3 deny");
    checkEq("R3 set after deny", {31'd0, protErr}, 32'd1);
    doReq(2'd1, 2'd0, 5, 1'b1, "R3 grant");
    checkEq("R3 sticky", {31'd0, protErr}, 32'd1);
    clearErr();
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd2; reqSrc = 2'd0; reqAddr = 17'h0; errClr = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; errClr = 1'b0;
    checkEq("R3 set wins over clear", {31'd0, protErr}, 32'd1);
    clearErr();
    wpBits = '1;
  endtask

  task automatic t_read_rdp();
    rdpActive = 1'b1;
    doReq(2'd0, 2'd0, 20, 1'b1, "R4 trusted cpu read");
    doReq(2'd0, 2'd1, 20, 1'b0, "R4 sram cpu read");
    doReq(2'd0, 2'd2, 20, 1'b0, "R4 dma read");
    doReq(2'd0, 2'd3, 20, 1'b0, "R4 debug port read");
    debugActive = 1'b1;
    doReq(2'd0, 2'd0, 20, 1'b0, "R4 cpu read with debug");
    debugActive = 1'b0; bootFromSram = 1'b1;
    doReq(2'd0, 2'd0, 20, 1'b0, "R4 cpu read after sram boot");
    bootFromSram = 1'b0;
    checkEq("R4 no error on read deny", {31'd0, protErr}, 32'd0);
    rdpActive = 1'b0;
  endtask

  task automatic t_read_open();
    wpBits = '0;
    for (int s = 0; s < 4; s++) doReq(2'd0, s[1:0], 3 + s * 30, 1'b1, "R8 open read");
    wpBits = '1;
  endtask

  task automatic t_rdp_auto();
    rdpActive = 1'b1; wpBits = '1;
    doReq(2'd1, 2'd0, 0, 1'b0, "R5 page0 auto lock");
    doReq(2'd2, 2'd0, 1, 1'b0, "R5 page1 auto lock");
    doReq(2'd1, 2'd0, 2, 1'b1, "R5 page2 open");
    rdpActive = 1'b0;
    doReq(2'd1, 2'd0, 0, 1'b1, "R5 page0 open without rdp");
    clearErr();
  endtask

  task automatic t_rdp_debug();
    rdpActive = 1'b1; debugActive = 1'b1;
    doReq(2'd1, 2'd0, 50, 1'b0, "R6 debug program");
    doReq(2'd2, 2'd0, 120, 1'b0, "R6 debug page erase");
    debugActive = 1'b0; bootFromSram = 1'b1;
    doReq(2'd1, 2'd1, 50, 1'b0, "R6 sram boot program");
    rdpActive = 1'b0;
    doReq(2'd1, 2'd1, 50, 1'b1, "R6 sram boot no rdp");
    debugActive = 1'b1;
    doReq(2'd2, 2'd3, 50, 1'b1, "R6 debug no rdp");
    debugActive = 1'b0; bootFromSram = 1'b0;
    clearErr();
  endtask

  task automatic t_mass();
    wpBits = '0; rdpActive = 1'b1; debugActive = 1'b1; bootFromSram = 1'b1;
    doReq(2'd3, 2'd3, 0, 1'b1, "R7 mass erase locked state");
    doReq(2'd3, 2'd2, 127, 1'b1, "R7 mass erase dma");
    checkEq("R7 no error", {31'd0, protErr}, 32'd0);
    wpBits = '1; rdpActive = 1'b0; debugActive = 1'b0; bootFromSram = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_upper();
    t_err();
    t_read_rdp();
    t_read_open();
    t_rdp_auto();
    t_rdp_debug();
    t_mass();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule